// File: doc/BRIEF.md
# Vertex Program Flow Sequencer

This block steers instruction fetch for a programmable vertex unit. After a start pulse carrying an entry address it issues one instruction address per cycle, strictly in program order, and picks the next address from the decoded kind of the current instruction. The choices are the next sequential slot, a jump target, a subroutine target, or an address taken from a small return stack. Jumps, calls and returns only take effect when the condition-code unit reports that their test passed. A test that is always true or always false is just a constant pass input.

The instruction store and the decoder sit outside the block. They answer the presented address within the same cycle, so a taken jump costs no bubble. A per-run step counter caps the number of issued instructions. When that budget is used up, a looping program is stopped with an abort pulse. An abort is also raised, together with a sticky stack fault flag, when a call finds the return stack full or a return finds it empty.

Top module: `vps_sequencer`

## Requirements
- R1: A start pulse loads the entry address, and that address is issued in the following cycle. Start also clears the step count, the return stack and the stack fault flag. `imem_addr` always equals `issue_pc`, and `imem_en` equals `issue_valid`.
- R2: An ordinary instruction (dec_op code 0) is followed in the next cycle by the issue of the address one higher, wrapping modulo 2^PC_W.
- R3: A jump (code 1) whose test passes makes `dec_target` the very next issued address, with no idle cycle in between.
- R4: A jump, call (code 2) or return (code 3) whose test fails is followed by the next sequential address and leaves the return stack untouched.
- R5: A passing call saves its own address plus one and continues at `dec_target`. A passing return continues at the most recently saved address and discards it.
- R6: Calls nest up to RS_DEPTH levels deep, and the returns unwind them in last-in first-out order.
- R7: A passing call made while RS_DEPTH addresses are saved ends the run with an abort pulse and sets `stack_err`.
- R8: A passing return made while no address is saved ends the run with an abort pulse and sets `stack_err`.
- R9: A run that issues MAX_STEPS instructions without reaching an end instruction stops after the MAX_STEPS-th issue with an abort pulse, and `stack_err` stays low.
- R10: An end instruction (code 4) is issued and ends the run. The following cycle carries a one-cycle `done` pulse and no further issue. An end instruction that is exactly the MAX_STEPS-th issue still gives `done`.
- R11: `done` and `aborted` are never high together, and each stays high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run at `entry_addr` |
| entry_addr | input | PC_W | First instruction address of the run |
| imem_addr | output | PC_W | Instruction store read address |
| imem_en | output | 1 | Instruction store read enable |
| dec_op | input | 3 | Decoded kind: 0 ordinary, 1 jump, 2 call, 3 return, 4 end |
| dec_target | input | PC_W | Decoded jump or call target |
| cc_pass | input | 1 | Condition-code test result for the current instruction |
| issue_valid | output | 1 | An instruction is issued this cycle |
| issue_pc | output | PC_W | Address of the issued instruction |
| done | output | 1 | One-cycle pulse after a normal end |
| aborted | output | 1 | One-cycle pulse after a budget or stack stop |
| stack_err | output | 1 | Last run stopped on a return stack fault (held until start) |

## Verification
The bench builds the block with PC_W = 8, RS_DEPTH = 4 and MAX_STEPS = 40. The budget limit is lowered so that a two-instruction loop exhausts it in a few dozen cycles. The same low limit lets an end instruction placed exactly on the last allowed step be reached. At depth 4, a self-recursive call fills the stack and overflows on its fifth entry, and a four-level nested program unwinds completely. The expected issue trace of each program comes from a behavioural walk over the bench's own program image.

// File: rtl/vps_pkg.sv
package vps_pkg;

    typedef enum logic [2:0] {
        OP_SEQ = 3'd0,
        OP_BRA = 3'd1,
        OP_CAL = 3'd2,
        OP_RET = 3'd3,
        OP_END = 3'd4
    } op_e;

    // control decision for one issued instruction
    typedef struct packed {
        logic push;
        logic pop;
        logic finish;
        logic fault;
    } flow_t;

    function automatic logic is_ctrl(op_e op);
        return (op == OP_BRA) || (op == OP_CAL) || (op == OP_RET);
    endfunction

endpackage

// File: rtl/vps_next_pc.sv
module vps_next_pc
    import vps_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] target,
    input  logic [PC_W-1:0] ret_addr,
    input  op_e             op,
    input  logic            cc_pass,
    input  logic            full,
    input  logic            empty,
    output logic [PC_W-1:0] nxt_pc,
    output flow_t           fl
);

    logic taken;

    always_comb begin
        taken  = is_ctrl(op) && cc_pass;
        nxt_pc = pc + 1'b1;
        fl     = '0;
        unique case (op)
            OP_BRA: if (taken) nxt_pc = target;
            OP_CAL: if (taken) begin
                if (full) fl.fault = 1'b1;
                else begin
                    fl.push = 1'b1;
                    nxt_pc  = target;
                end
            end
            OP_RET: if (taken) begin
                if (empty) fl.fault = 1'b1;
                else begin
                    fl.pop = 1'b1;
                    nxt_pc = ret_addr;
                end
            end
            OP_END: fl.finish = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/vps_ret_stack.sv
module vps_ret_stack #(
    parameter int PC_W  = 8,
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            push,
    input  logic            pop,
    input  logic [PC_W-1:0] din,
    output logic [PC_W-1:0] top,
    output logic            full,
    output logic            empty
);

    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    logic [PC_W-1:0] slots [DEPTH];
    logic [SP_W-1:0] sp;
    logic [SP_W-1:0] sp_m1;

    assign sp_m1 = sp - 1'b1;
    assign top   = slots[sp_m1[IDX_W-1:0]];
    assign full  = (sp == SP_W'(DEPTH));
    assign empty = (sp == '0);

    always_ff @(posedge clk) begin
        if (rst || clear) sp <= '0;
        else if (push)    sp <= sp + 1'b1;
        else if (pop)     sp <= sp_m1;
    end

    always_ff @(posedge clk) begin
        if (push && !clear) slots[sp[IDX_W-1:0]] <= din;
    end

    // R7: the selector never pushes onto a full stack
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R8: the selector never pops an empty stack
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
    // R6: a push followed by a pop returns the pushed address
    p_lifo_r6: assert property (@(posedge clk) disable iff (rst)
        push && !clear |=> top == $past(din));

endmodule

// File: rtl/vps_step_budget.sv
module vps_step_budget #(
    parameter int MAX_STEPS = 65536
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic step,
    output logic last
);

    localparam int CNT_W = $clog2(MAX_STEPS + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(MAX_STEPS - 1);

    logic [CNT_W-1:0] cnt;

    assign last = (cnt == LAST_CNT);

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (step)    cnt <= cnt + 1'b1;
    end

    // R9: no instruction is issued beyond the budget
    p_budget_cap_r9: assert property (@(posedge clk) disable iff (rst)
        step |-> cnt < CNT_W'(MAX_STEPS));

endmodule

// File: rtl/vps_sequencer.sv
module vps_sequencer
    import vps_pkg::*;
#(
    parameter int PC_W      = 8,
    parameter int RS_DEPTH  = 4,
    parameter int MAX_STEPS = 65536
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [PC_W-1:0] entry_addr,
    output logic [PC_W-1:0] imem_addr,
    output logic            imem_en,
    input  logic [2:0]      dec_op,
    input  logic [PC_W-1:0] dec_target,
    input  logic            cc_pass,
    output logic            issue_valid,
    output logic [PC_W-1:0] issue_pc,
    output logic            done,
    output logic            aborted,
    output logic            stack_err
);

    logic            running;
    logic [PC_W-1:0] pc;
    logic            done_q, abort_q, err_q;

    op_e             op;
    flow_t           fl;
    logic [PC_W-1:0] nxt_pc, ret_addr;
    logic            rs_full, rs_empty, last;
    logic            advance, do_push, do_pop, stop_ok, stop_bad;

    assign op       = op_e'(dec_op);
    assign advance  = running && !start;
    assign stop_ok  = fl.finish;
    assign stop_bad = fl.fault || (last && !fl.finish);
    assign do_push  = advance && fl.push && !last;
    assign do_pop   = advance && fl.pop && !last;

    vps_next_pc #(.PC_W(PC_W)) u_sel (
        .pc       (pc),
        .target   (dec_target),
        .ret_addr (ret_addr),
        .op       (op),
        .cc_pass  (cc_pass),
        .full     (rs_full),
        .empty    (rs_empty),
        .nxt_pc   (nxt_pc),
        .fl       (fl)
    );

    vps_ret_stack #(.PC_W(PC_W), .DEPTH(RS_DEPTH)) u_stack (
        .clk   (clk),
        .rst   (rst),
        .clear (start),
        .push  (do_push),
        .pop   (do_pop),
        .din   (PC_W'(pc + 1'b1)),
        .top   (ret_addr),
        .full  (rs_full),
        .empty (rs_empty)
    );

    vps_step_budget #(.MAX_STEPS(MAX_STEPS)) u_budget (
        .clk   (clk),
        .rst   (rst),
        .clear (start),
        .step  (advance),
        .last  (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            pc      <= '0;
            done_q  <= 1'b0;
            abort_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            abort_q <= 1'b0;
            if (start) begin
                running <= 1'b1;
                pc      <= entry_addr;
                err_q   <= 1'b0;
            end else if (running) begin
                if (stop_ok) begin
                    running <= 1'b0;
                    done_q  <= 1'b1;
                end else if (stop_bad) begin
                    running <= 1'b0;
                    abort_q <= 1'b1;
                    err_q   <= fl.fault;
                end else begin
                    pc <= nxt_pc;
                end
            end
        end
    end

    assign imem_addr   = pc;
    assign imem_en     = running;
    assign issue_valid = running;
    assign issue_pc    = pc;
    assign done        = done_q;
    assign aborted     = abort_q;
    assign stack_err   = err_q;

    // R1: start issues the entry address next cycle
    p_start_entry_r1: assert property (@(posedge clk) disable iff (rst)
        start |=> issue_valid && issue_pc == $past(entry_addr));
    // R2: ordinary instruction advances by one
    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        issue_valid && !start && !last && dec_op == OP_SEQ
        |=> issue_valid && issue_pc == PC_W'($past(issue_pc) + 1'b1));
    // R3: taken jump lands on its target with no bubble
    p_bra_taken_r3: assert property (@(posedge clk) disable iff (rst)
        issue_valid && !start && !last && dec_op == OP_BRA && cc_pass
        |=> issue_valid && issue_pc == $past(dec_target));
    // R10: end instruction gives done and stops issue
    p_end_done_r10: assert property (@(posedge clk) disable iff (rst)
        issue_valid && !start && dec_op == OP_END |=> done && !issue_valid);
    // R11: completion pulses exclusive and single-cycle
    p_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(done && aborted));
    p_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done || aborted |=> !done && !aborted);

endmodule

// File: tb/vps_sequencer_test.sv
module vps_sequencer_test;
    import vps_pkg::*;

    localparam int PC_W = 8;
    localparam int DEPTH = 4;
    localparam int MAXS = 40;
    localparam int TOK_DONE = 1000;
    localparam int TOK_ABORT = 2000;

    logic clk = 1'b0;
    logic rst, start;
    logic [PC_W-1:0] entry_addr, imem_addr, dec_target, issue_pc;
    logic [2:0] dec_op;
    logic imem_en, cc_pass, issue_valid, done, aborted, stack_err;

    always #2.5 clk = ~clk;

    vps_sequencer #(.PC_W(PC_W), .RS_DEPTH(DEPTH), .MAX_STEPS(MAXS)) uut (
        .clk(clk), .rst(rst), .start(start), .entry_addr(entry_addr),
        .imem_addr(imem_addr), .imem_en(imem_en), .dec_op(dec_op),
        .dec_target(dec_target), .cc_pass(cc_pass), .issue_valid(issue_valid),
        .issue_pc(issue_pc), .done(done), .aborted(aborted), .stack_err(stack_err)
    );

    // program image
    logic [2:0]      op_mem  [256];
    logic [PC_W-1:0] tgt_mem [256];
    logic            cc_mem  [256];

    always_comb begin
        dec_op     = op_mem[imem_addr];
        dec_target = tgt_mem[imem_addr];
        cc_pass    = cc_mem[imem_addr];
    end

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    logic exp_err;
    string cur_req = "R0";

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (issue_valid) begin
                if (exp_q.size() == 0) check(cur_req, int'(issue_pc), -1);
                else check(cur_req, int'(issue_pc), exp_q.pop_front());
            end
            if (done) begin
                if (exp_q.size() == 0) check(cur_req, TOK_DONE, -1);
                else check(cur_req, TOK_DONE, exp_q.pop_front());
            end
            if (aborted) begin
                if (exp_q.size() == 0) check(cur_req, TOK_ABORT, -1);
                else check(cur_req, TOK_ABORT, exp_q.pop_front());
            end
        end
    end

    // driver: walks the program image by the stated rules, queues the trace
    task automatic build_expect(int entry);
        int pc = entry;
        int stk[$];
        for (int n = 1; n <= MAXS; n++) begin
            int nxt;
            bit fault;
            exp_q.push_back(pc);
            if (op_mem[pc] == OP_END) begin
                exp_q.push_back(TOK_DONE); exp_err = 1'b0; return;
            end
            nxt = (pc + 1) % 256;
            fault = 1'b0;
            if (cc_mem[pc]) begin
                case (op_mem[pc])
                    OP_BRA: nxt = tgt_mem[pc];
                    OP_CAL: if (stk.size() == DEPTH) fault = 1'b1;
                            else begin stk.push_back((pc + 1) % 256); nxt = tgt_mem[pc]; end
                    OP_RET: if (stk.size() == 0) fault = 1'b1;
                            else nxt = stk.pop_back();
                    default: ;
                endcase
            end
            if (fault) begin
                exp_q.push_back(TOK_ABORT); exp_err = 1'b1; return;
            end
            if (n == MAXS) begin
                exp_q.push_back(TOK_ABORT); exp_err = 1'b0; return;
            end
            pc = nxt;
        end
    endtask

    task automatic run_prog(string req, int entry);
        cur_req = req;
        exp_q.delete();
        build_expect(entry);
        @(negedge clk);
        start = 1'b1; entry_addr = PC_W'(entry);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        check({req, " trace drained"}, exp_q.size(), 0);
        check({req, " stack_err"}, int'(stack_err), int'(exp_err));
        check({req, " idle"}, int'(issue_valid), 0);
    endtask

    task automatic set_op(int a, op_e o, int t, bit c);
        op_mem[a] = o; tgt_mem[a] = PC_W'(t); cc_mem[a] = c;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) set_op(a, OP_SEQ, 0, 1'b0);
        // R1, R2, R10: straight line
        set_op(12, OP_END, 0, 1'b1);
        // R3, R4: taken jump, untaken jump, untaken call
        set_op(20, OP_BRA, 25, 1'b1);
        set_op(25, OP_BRA, 40, 1'b0);
        set_op(26, OP_CAL, 90, 1'b0);
        set_op(27, OP_END, 0, 1'b1);
        // R5, R6: four-level nesting, untaken return at 90
        set_op(50, OP_CAL, 60, 1'b1); set_op(51, OP_END, 0, 1'b1);
        set_op(60, OP_CAL, 70, 1'b1); set_op(61, OP_RET, 0, 1'b1);
        set_op(70, OP_CAL, 80, 1'b1); set_op(71, OP_RET, 0, 1'b1);
        set_op(80, OP_CAL, 90, 1'b1); set_op(81, OP_RET, 0, 1'b1);
        set_op(90, OP_RET, 0, 1'b0);  set_op(91, OP_RET, 0, 1'b1);
        // R7: self-recursive call overflows
        set_op(100, OP_CAL, 100, 1'b1);
        // R8: return on empty stack
        set_op(120, OP_RET, 0, 1'b1);
        // R9: endless loop
        set_op(131, OP_BRA, 130, 1'b1);
        // R10: end exactly on last budget step (140..179 = 40 issues)
        set_op(179, OP_END, 0, 1'b1);

        rst = 1'b1; start = 1'b0; entry_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset issue_valid", int'(issue_valid), 0);
        check("R11 reset done", int'(done), 0);
        check("R11 reset aborted", int'(aborted), 0);
        check("R7 reset stack_err", int'(stack_err), 0);

        run_prog("R2", 10);
        run_prog("R3", 20);
        run_prog("R5", 50);
        run_prog("R7", 100);
        run_prog("R1", 10);
        run_prog("R8", 120);
        run_prog("R9", 130);
        run_prog("R10", 140);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule